// File: doc/BRIEF.md
# Programmable Event Counter Bank with Overflow Summary

This block holds a bank of `NUM_CTRS` programmable 64-bit event counters. Each counter has a selector register that names one event ID. When an event pulse arrives, it carries an event ID and a per-counter match vector, which an external transaction filter has already worked out. On that pulse, every counter that passes all of the following increments: its match bit is set, it is not inhibited, and its selector names the incoming event. Several counters may watch the same event and then all count together.

When a counter wraps from all-ones, the bank sets that counter's overflow flag in its selector and mirrors it into a shared overflow summary vector. It also raises a performance-monitor interrupt pulse, but only when the summary bit was clear beforehand. Bit 0 of the summary vector and of the inhibit vector belongs to a cycle counter outside this block, so counter `i` uses bit `i+1`.

Software can write selectors and counters through a single write port and read them back through an index-addressed read port. Selector writes legalise the event ID field. A selector write with its overflow flag clear acknowledges the overflow by clearing the summary bit.

Top module: `evt_ctr_bank`

## Requirements
- R1: After reset all counters and selectors read 0, `ovf_sum_o` is 0 and `irq_o` is low.
- R2: Counter i increments by 1 at a clock edge where `evt_valid_i`=1, `evt_match_i[i]`=1, `inhibit_i[i+1]`=0, and the selector's event ID (selector bits [EVT_ID_W-1:0]) is nonzero and equals `evt_id_i`.
- R3: A counter whose `inhibit_i[i+1]` is 1 never increments. `inhibit_i[0]` has no effect on the bank.
- R4: All counters whose selectors name the same event and whose match bits are set increment on the same pulse.
- R5: A selector write stores event ID 0 when the written ID is 0 or at least `EVT_ID_MAX`; otherwise it stores the written ID. A counter with ID 0 never counts.
- R6: Selector or counter writes with `wr_idx_i` >= `NUM_CTRS` change no state.
- R7: An increment from all-ones gives 0. If summary bit i+1 was clear, it sets that bit and the selector's overflow flag (selector bit EVT_ID_W), and `irq_o` is high for exactly the cycle after that edge.
- R8: A wrap that happens while summary bit i+1 is already set raises no interrupt and leaves the summary unchanged.
- R9: A selector write with overflow flag 0 clears summary bit i+1. A write with flag 1 stores the flag and leaves the summary bit unchanged.
- R10: Wraps of several counters at the same edge set all their summary bits and produce a single one-cycle `irq_o` pulse.
- R11: A counter write loads `wr_data_i`. A counter that receives a selector or counter write at an edge does not count at that edge.
- R12: `ovf_sum_o[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_valid_i | input | 1 | Event pulse |
| evt_id_i | input | EVT_ID_W | Event ID of the pulse |
| evt_match_i | input | NUM_CTRS | Filter result, one bit per counter |
| inhibit_i | input | NUM_CTRS+1 | Inhibit vector; bit i+1 stops counter i, bit 0 unused here |
| sel_we_i | input | 1 | Selector write strobe |
| ctr_we_i | input | 1 | Counter write strobe |
| wr_idx_i | input | IDX_W | Index of the written counter or selector |
| wr_data_i | input | CTR_W | Write data; selector uses bits [EVT_ID_W:0] |
| rd_idx_i | input | IDX_W | Readback index |
| ctr_rd_o | output | CTR_W | Counter value at `rd_idx_i` (0 if out of range) |
| sel_rd_o | output | EVT_ID_W+1 | Selector at `rd_idx_i`: {overflow flag, event ID} |
| ovf_sum_o | output | NUM_CTRS+1 | Overflow summary vector |
| irq_o | output | 1 | Performance-monitor interrupt pulse |

## Verification
A wrong match or inhibit decision shows up as a counter value that differs on readback one edge after the pulse. Because every counter is read back on every cycle, no such error can stay hidden. A summary bit or overflow flag that is lost or set in error changes `ovf_sum_o` or `sel_rd_o` at the same edge, and it changes `irq_o` one cycle later. If interrupt merging is broken, the coincident-wrap case shows a second pulse or a missing one. Legalisation errors appear as a stored ID other than 0 right after the write.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  parameter int unsigned DEF_NUM_CTRS  = 8;
  parameter int unsigned DEF_CTR_W     = 64;
  parameter int unsigned DEF_EVT_ID_W  = 8;
  parameter int unsigned DEF_EVT_ID_MAX = 16;
endpackage

// File: rtl/evt_id_legalize.sv
module evt_id_legalize #(
  parameter int unsigned EVT_ID_W   = 8,
  parameter int unsigned EVT_ID_MAX = 16
) (
  input  logic [EVT_ID_W-1:0] id_i,
  output logic [EVT_ID_W-1:0] id_o
);
  localparam logic [EVT_ID_W:0] MAX_EXT = (EVT_ID_W+1)'(EVT_ID_MAX);

  always_comb begin
    if (id_i == '0 || {1'b0, id_i} >= MAX_EXT) id_o = '0;
    else id_o = id_i;
  end
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice #(
  parameter int unsigned CTR_W      = 64,
  parameter int unsigned EVT_ID_W   = 8,
  parameter int unsigned EVT_ID_MAX = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_i,
  input  logic [EVT_ID_W-1:0] evt_id_i,
  input  logic                sel_we_i,
  input  logic                ctr_we_i,
  input  logic [CTR_W-1:0]    wdata_i,
  output logic [CTR_W-1:0]    cnt_o,
  output logic [EVT_ID_W-1:0] sel_id_o,
  output logic                sel_of_o,
  output logic                sum_o,
  output logic                wrap_new_o
);
  logic [CTR_W-1:0]    cnt_q;
  logic [EVT_ID_W-1:0] id_q, id_legal;
  logic                of_q, sum_q, hit, wrap_new;

  evt_id_legalize #(.EVT_ID_W(EVT_ID_W), .EVT_ID_MAX(EVT_ID_MAX)) legal_i (
    .id_i (wdata_i[EVT_ID_W-1:0]),
    .id_o (id_legal)
  );

  // software access to this slice wins over counting
  assign hit      = inc_i && !sel_we_i && !ctr_we_i && id_q != '0 && id_q == evt_id_i;
  assign wrap_new = hit && (&cnt_q) && !sum_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      id_q  <= '0;
      of_q  <= 1'b0;
      sum_q <= 1'b0;
    end else begin
      if (ctr_we_i)  cnt_q <= wdata_i;
      else if (hit)  cnt_q <= cnt_q + 1'b1;
      if (sel_we_i) begin
        id_q <= id_legal;
        of_q <= wdata_i[EVT_ID_W];
        if (!wdata_i[EVT_ID_W]) sum_q <= 1'b0;
      end else if (wrap_new) begin
        of_q  <= 1'b1;
        sum_q <= 1'b1;
      end
    end
  end

  assign cnt_o      = cnt_q;
  assign sel_id_o   = id_q;
  assign sel_of_o   = of_q;
  assign sum_o      = sum_q;
  assign wrap_new_o = wrap_new;

  AST_INHIBIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !ctr_we_i) |=> $stable(cnt_q)); // R3
  AST_ZERO_ID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_q == '0 && !ctr_we_i) |=> $stable(cnt_q)); // R5
  AST_ID_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_q == '0 || 32'(id_q) < EVT_ID_MAX)); // R5
  AST_WRAP_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !sel_we_i && !ctr_we_i && id_q != '0 && id_q == evt_id_i && (&cnt_q) && !sum_q)
      |=> (sum_q && of_q && cnt_q == '0)); // R7
  AST_SUM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_q && !sel_we_i) |=> sum_q); // R8
endmodule

// File: rtl/evt_ctr_bank.sv
module evt_ctr_bank
  import evt_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTRS   = DEF_NUM_CTRS,
  parameter int unsigned CTR_W      = DEF_CTR_W,
  parameter int unsigned EVT_ID_W   = DEF_EVT_ID_W,
  parameter int unsigned EVT_ID_MAX = DEF_EVT_ID_MAX,
  localparam int unsigned IDX_W     = $clog2(NUM_CTRS) + 1,
  localparam int unsigned SEL_W     = EVT_ID_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                evt_valid_i,
  input  logic [EVT_ID_W-1:0] evt_id_i,
  input  logic [NUM_CTRS-1:0] evt_match_i,
  input  logic [NUM_CTRS:0]   inhibit_i,
  input  logic                sel_we_i,
  input  logic                ctr_we_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [CTR_W-1:0]    wr_data_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [CTR_W-1:0]    ctr_rd_o,
  output logic [SEL_W-1:0]    sel_rd_o,
  output logic [NUM_CTRS:0]   ovf_sum_o,
  output logic                irq_o
);
  logic [CTR_W-1:0]    cnt   [NUM_CTRS];
  logic [EVT_ID_W-1:0] sel_id[NUM_CTRS];
  logic [NUM_CTRS-1:0] sel_of, sum, wrap_new;
  logic                irq_q;

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    logic sel_we_g, ctr_we_g, inc_g;
    assign sel_we_g = sel_we_i && wr_idx_i == IDX_W'(g);
    assign ctr_we_g = ctr_we_i && wr_idx_i == IDX_W'(g);
    assign inc_g    = evt_valid_i && evt_match_i[g] && !inhibit_i[g+1];

    evt_ctr_slice #(.CTR_W(CTR_W), .EVT_ID_W(EVT_ID_W), .EVT_ID_MAX(EVT_ID_MAX)) slice_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .inc_i      (inc_g),
      .evt_id_i   (evt_id_i),
      .sel_we_i   (sel_we_g),
      .ctr_we_i   (ctr_we_g),
      .wdata_i    (wr_data_i),
      .cnt_o      (cnt[g]),
      .sel_id_o   (sel_id[g]),
      .sel_of_o   (sel_of[g]),
      .sum_o      (sum[g]),
      .wrap_new_o (wrap_new[g])
    );
  end

  // coincident causes merge into one pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |wrap_new;
  end

  always_comb begin
    ctr_rd_o = '0;
    sel_rd_o = '0;
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (rd_idx_i == IDX_W'(i)) begin
        ctr_rd_o = cnt[i];
        sel_rd_o = {sel_of[i], sel_id[i]};
      end
    end
  end

  assign ovf_sum_o = {sum, 1'b0};
  assign irq_o     = irq_q;

  AST_SUM_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_sum_o[0]); // R12
  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_sum_o != $past(ovf_sum_o))); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(sel_we_i)) |=> !irq_o || (ovf_sum_o != $past(ovf_sum_o))); // R10
endmodule

// File: tb/evt_ctr_bank_tb_top.sv
`timescale 1ns/1ps
module evt_ctr_bank_tb_top;
  localparam int N = 8;
  localparam int IW = 4;

  logic clk = 0, rst_ni = 0;
  logic evt_valid_i = 0;
  logic [7:0] evt_id_i = 0;
  logic [N-1:0] evt_match_i = 0;
  logic [N:0] inhibit_i = 0;
  logic sel_we_i = 0, ctr_we_i = 0;
  logic [IW-1:0] wr_idx_i = 0, rd_idx_i = 0;
  logic [63:0] wr_data_i = 0, ctr_rd_o;
  logic [8:0] sel_rd_o;
  logic [N:0] ovf_sum_o;
  logic irq_o;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  logic [63:0] m_cnt[N];
  int m_id[N];
  bit m_of[N];
  bit [N:0] m_sum;
  bit m_irq;

  always #2 clk = ~clk;

  evt_ctr_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .evt_valid_i(evt_valid_i), .evt_id_i(evt_id_i),
    .evt_match_i(evt_match_i), .inhibit_i(inhibit_i), .sel_we_i(sel_we_i),
    .ctr_we_i(ctr_we_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i), .rd_idx_i(rd_idx_i),
    .ctr_rd_o(ctr_rd_o), .sel_rd_o(sel_rd_o), .ovf_sum_o(ovf_sum_o), .irq_o(irq_o));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R7/R8/R10 irq", {63'd0, irq_o}, {63'd0, m_irq});
    chk("R9/R12 summary", {55'd0, ovf_sum_o}, {55'd0, m_sum});
    for (int i = 0; i < N; i++) begin
      rd_idx_i = IW'(i);
      #0.2;
      chk("R2/R3/R4/R11 counter", ctr_rd_o, m_cnt[i]);
      chk("R5/R7 selector", {55'd0, sel_rd_o}, {55'd0, m_of[i], 8'(m_id[i])});
    end
    rd_idx_i = IW'(N + 1);
    #0.2;
    chk("R6 readback out of range", ctr_rd_o, 64'd0);
  endtask

  task automatic cyc(bit ev, int id, bit [N-1:0] match, bit [N:0] inh,
                     bit swe, bit cwe, int idx, logic [63:0] data);
    evt_valid_i = ev; evt_id_i = 8'(id); evt_match_i = match; inhibit_i = inh;
    sel_we_i = swe; ctr_we_i = cwe; wr_idx_i = IW'(idx); wr_data_i = data;
    @(posedge clk);
    m_irq = 0;
    for (int i = 0; i < N; i++) begin
      bit ws, wc, hit;
      ws = swe && idx == i;
      wc = cwe && idx == i;
      hit = ev && match[i] && !inh[i+1] && m_id[i] == id && m_id[i] != 0 && !ws && !wc;
      if (wc) m_cnt[i] = data;
      else if (hit) begin
        if (m_cnt[i] == '1) begin
          m_cnt[i] = 0;
          if (!m_sum[i+1]) begin m_sum[i+1] = 1; m_of[i] = 1; m_irq = 1; end
        end else m_cnt[i] = m_cnt[i] + 1;
      end
      if (ws) begin
        int lid;
        lid = int'(data[7:0]);
        m_id[i] = (lid == 0 || lid >= 16) ? 0 : lid;
        m_of[i] = data[8];
        if (!data[8]) m_sum[i+1] = 0;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic wsel(int idx, int id, bit of);
    cyc(0, 0, 0, 0, 1, 0, idx, {55'd0, of, 8'(id)});
  endtask
  task automatic wctr(int idx, logic [63:0] v);
    cyc(0, 0, 0, 0, 0, 1, idx, v);
  endtask
  task automatic ev(int id, bit [N-1:0] match, bit [N:0] inh);
    cyc(1, id, match, inh, 0, 0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_cnt[i] = 0; m_id[i] = 0; m_of[i] = 0; end
    m_sum = 0; m_irq = 0;
    #10; @(negedge clk); rst_ni = 1;
    compare_all(); // R1 reset state
    // R5 legalisation: 0, 200 and 16 store 0
    wsel(0, 3, 0); wsel(1, 3, 0); wsel(2, 5, 0); wsel(3, 0, 0);
    wsel(4, 200, 0); wsel(5, 16, 0); wsel(6, 15, 0); wsel(7, 3, 0);
    // R6 out-of-range writes
    wsel(9, 3, 1); wctr(12, 64'hdead); wsel(15, 5, 0);
    // R2 R4 basic and shared events
    ev(3, 8'hff, 0); ev(3, 8'hff, 0); ev(5, 8'hff, 0); ev(15, 8'h40, 0);
    ev(0, 8'hff, 0); // R5 id 0 never counts
    ev(3, 8'h01, 0); ev(3, 8'h82, 0);
    // R3 inhibit bit 2 stops counter 1, bit 0 has no effect
    ev(3, 8'hff, 9'h004); ev(3, 8'hff, 9'h001); ev(3, 8'hff, 9'h1fe);
    // R11 writes collide with events
    cyc(1, 3, 8'hff, 0, 0, 1, 0, 64'd100);
    cyc(1, 3, 8'hff, 0, 1, 0, 1, 64'd3);
    // mixed traffic
    for (int k = 0; k < 300; k++)
      ev(($urandom % 3 == 0) ? 5 : (($urandom % 2) ? 3 : 15), 8'($urandom), 9'($urandom) & 9'h0aa);
    // R10 coincident wraps
    wctr(0, '1); wctr(7, '1); ev(3, 8'h81, 0); ev(0, 0, 0);
    // R8 wrap while summary set
    wctr(0, '1); ev(3, 8'h01, 0); ev(0, 0, 0);
    // R9 clear with OF=0, keep with OF=1
    wsel(0, 3, 0); wsel(7, 3, 1);
    // R7 single wrap after acknowledge
    wctr(0, 64'hffff_ffff_ffff_fffe); ev(3, 8'h01, 0); ev(3, 8'h01, 0); ev(3, 8'h01, 0);
    // R11 counter write loads data
    wctr(2, 64'h1234_5678_9abc_def0); ev(5, 8'h04, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule